// File: doc/BRIEF.md
# Port-Limited Operand Read Scheduler

This block sits at the issue point of a single-issue in-order pipeline. Decode hands it one instruction at a time as a set of up to eight operand slots. Each slot carries a valid bit, a memory flag, a 3-bit register class code and a 7-bit register number. The block captures the slot set and then spends as many cycles as needed reading every register operand.

In each cycle the block grants reads to pending operands. It never grants more reads in one cycle than the read-port budget of each register class. Each class has its own budget, so reads from different classes proceed side by side. Each granted operand leaves the pending set. When the last operands are granted, the block pulses `issue_o` in that same cycle. It holds decode stalled from the cycle after capture until the cycle after issue.

Memory operands are dropped at capture and never use a port. Register storage, writeback and memory access are outside this block. The per-cycle grant mask, together with the held class and register number of each slot, tells the register files which entries to read.

Top module: `opnd_read_sched`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `stall_o`, `issue_o`, `grant_o` and every field of `grant_cnt_o` are zero.
- R2: When `stall_o` is low and `in_valid_i` is high at a clock edge, the slot set is captured. `stall_o` is then high from the next cycle up to and including the cycle in which `issue_o` is high.
- R3: Class codes and per-cycle read limits are: 0 integer (4), 1 floating-point (3), 2 whole condition register (1), 3 condition field (3), 4 fixed-point exception register (1), 5 floating-point status (1), 6 fast special-purpose (3), 7 slow special-purpose (1). Field c of `grant_cnt_o` (bits 4c+3..4c) equals the number of slots of class c granted in that cycle, and never exceeds the limit.
- R4: Budgets are independent per class. In one cycle, each class with pending operands receives min(pending, limit) grants, whatever the other classes are doing.
- R5: Within a class, pending slots are granted in ascending slot index order. Bit i of `grant_o` is slot i.
- R6: A granted slot leaves the pending set and is not granted again for the same instruction.
- R7: `issue_o` is high for exactly one cycle: the cycle in which the last pending operands are granted. `stall_o` is low in the following cycle.
- R8: A slot with its bit of `op_mem_i` set is never granted and does not delay issue.
- R9: An instruction with no register operands pulses `issue_o` in the cycle after capture, with `grant_o` zero.
- R10: While `stall_o` is high, `in_valid_i` and the slot inputs have no effect. A waiting instruction is captured in the cycle after `issue_o`, and its grants start one cycle later.
- R11: For each granted slot i, `grant_class_o` field i and `grant_reg_o` field i hold the class code and register number captured for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decode presents an instruction |
| op_valid_i | input | 8 | Per-slot operand present |
| op_mem_i | input | 8 | Per-slot memory operand flag |
| op_class_i | input | 24 | Per-slot 3-bit class code, slot i at bits 3i+2..3i |
| op_reg_i | input | 56 | Per-slot 7-bit register number, slot i at bits 7i+6..7i |
| stall_o | output | 1 | Hold decode; an instruction is being read |
| issue_o | output | 1 | Instruction issues this cycle |
| grant_o | output | 8 | Per-slot read grant this cycle |
| grant_cnt_o | output | 32 | Per-class grant count, 4 bits per class |
| grant_class_o | output | 24 | Held class code per slot |
| grant_reg_o | output | 56 | Held register number per slot |

## Verification
The final grants and the issue pulse fall in the same cycle. So does a read-limited class, still draining, beside a class that finishes at once. Mixed instructions provoke both cases: six integer operands with one condition-field operand, and four slow special-purpose operands, each of which needs its own cycle. A behavioural model with per-class counters predicts the grant mask, the per-class counts and the issue cycle, and the bench compares them on every clock. Random instructions mix in memory slots and `in_valid_i` held high during stalls, so back-to-back capture right after issue is also judged.

// File: rtl/opnd_read_sched_pkg.sv
package opnd_read_sched_pkg;
  localparam int unsigned CLASS_W     = 3;
  localparam int unsigned NUM_CLASSES = 1 << CLASS_W;

  typedef enum logic [CLASS_W-1:0] {
    CLS_INT   = 3'd0,
    CLS_FLT   = 3'd1,
    CLS_CRALL = 3'd2,
    CLS_CRFLD = 3'd3,
    CLS_XER   = 3'd4,
    CLS_FPST  = 3'd5,
    CLS_SPRF  = 3'd6,
    CLS_SPRS  = 3'd7
  } rf_class_e;

  function automatic int unsigned rd_ports(int unsigned cls);
    case (cls)
      0:       return 4;
      1, 3, 6: return 3;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/opnd_class_pick.sv
// Grants up to LIMIT pending slots of one class, lowest index first.
module opnd_class_pick #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned CLASS_W   = 3,
  parameter int unsigned CNT_W     = 4,
  parameter logic [CLASS_W-1:0] CLASS_ID = '0,
  parameter int unsigned LIMIT     = 1
) (
  input  logic [NUM_SLOTS-1:0]         pend_i,
  input  logic [NUM_SLOTS*CLASS_W-1:0] cls_i,
  output logic [NUM_SLOTS-1:0]         grant_o,
  output logic [CNT_W-1:0]             cnt_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  always_comb begin
    grant_o = '0;
    cnt_o   = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (pend_i[i] && cls_i[i*CLASS_W +: CLASS_W] == CLASS_ID && cnt_o < LIM) begin
        grant_o[i] = 1'b1;
        cnt_o      = cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/opnd_slot_store.sv
// Holds class and register number of each slot for the life of an instruction.
module opnd_slot_store #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned CLASS_W   = 3,
  parameter int unsigned REG_W     = 7
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [NUM_SLOTS*CLASS_W-1:0] cls_i,
  input  logic [NUM_SLOTS*REG_W-1:0]   reg_i,
  output logic [NUM_SLOTS*CLASS_W-1:0] cls_o,
  output logic [NUM_SLOTS*REG_W-1:0]   reg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_o <= '0;
      reg_o <= '0;
    end else if (load_i) begin
      cls_o <= cls_i;
      reg_o <= reg_i;
    end
  end
endmodule

// File: rtl/opnd_read_sched.sv
module opnd_read_sched
  import opnd_read_sched_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned REG_W     = 7,
  localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             in_valid_i,
  input  logic [NUM_SLOTS-1:0]             op_valid_i,
  input  logic [NUM_SLOTS-1:0]             op_mem_i,
  input  logic [NUM_SLOTS*CLASS_W-1:0]     op_class_i,
  input  logic [NUM_SLOTS*REG_W-1:0]       op_reg_i,
  output logic                             stall_o,
  output logic                             issue_o,
  output logic [NUM_SLOTS-1:0]             grant_o,
  output logic [NUM_CLASSES*CNT_W-1:0]     grant_cnt_o,
  output logic [NUM_SLOTS*CLASS_W-1:0]     grant_class_o,
  output logic [NUM_SLOTS*REG_W-1:0]       grant_reg_o
);
  logic                 busy_q;
  logic [NUM_SLOTS-1:0] pend_q, pend_next, grant;
  logic [NUM_SLOTS-1:0] grant_c [NUM_CLASSES];
  logic                 accept;

  assign accept = !busy_q && in_valid_i;

  opnd_slot_store #(
    .NUM_SLOTS(NUM_SLOTS), .CLASS_W(CLASS_W), .REG_W(REG_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .cls_i  (op_class_i),
    .reg_i  (op_reg_i),
    .cls_o  (grant_class_o),
    .reg_o  (grant_reg_o)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    opnd_class_pick #(
      .NUM_SLOTS(NUM_SLOTS), .CLASS_W(CLASS_W), .CNT_W(CNT_W),
      .CLASS_ID(CLASS_W'(c)), .LIMIT(rd_ports(c))
    ) u_pick (
      .pend_i  (pend_q),
      .cls_i   (grant_class_o),
      .grant_o (grant_c[c]),
      .cnt_o   (grant_cnt_o[c*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    grant = '0;
    for (int c = 0; c < NUM_CLASSES; c++) grant = grant | grant_c[c];
  end

  assign pend_next = pend_q & ~grant;
  assign grant_o   = grant;
  assign stall_o   = busy_q;
  assign issue_o   = busy_q && (pend_next == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      pend_q <= op_valid_i & ~op_mem_i;   // memory operands never need a port
    end else if (busy_q) begin
      pend_q <= pend_next;
      if (issue_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/opnd_read_sched_chk.sv
module opnd_read_sched_chk
  import opnd_read_sched_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned CNT_W     = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         in_valid_i,
  input logic                         stall_o,
  input logic                         issue_o,
  input logic [NUM_SLOTS-1:0]         grant_o,
  input logic [NUM_CLASSES*CNT_W-1:0] grant_cnt_o
);
  int unsigned cnt_sum;
  always_comb begin
    cnt_sum = 0;
    for (int c = 0; c < NUM_CLASSES; c++) cnt_sum += grant_cnt_o[c*CNT_W +: CNT_W];
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_lim
    AST_CLASS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_cnt_o[c*CNT_W +: CNT_W] <= CNT_W'(rd_ports(c))); // R3
  end

  AST_CNT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o) == cnt_sum); // R4
  AST_ACCEPT_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && in_valid_i) |=> stall_o); // R2
  AST_IDLE_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> (grant_o == '0 && !issue_o)); // R2
  AST_NO_REGRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> ((grant_o & $past(grant_o)) == '0)); // R6
  AST_ISSUE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> (!stall_o && !issue_o)); // R7
  AST_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !issue_o) |-> (grant_o != '0)); // R4
endmodule

bind opnd_read_sched opnd_read_sched_chk #(
  .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .stall_o     (stall_o),
  .issue_o     (issue_o),
  .grant_o     (grant_o),
  .grant_cnt_o (grant_cnt_o)
);

// File: tb/tb_opnd_read_sched.sv
`timescale 1ns/1ps
module tb_opnd_read_sched;
  localparam int NS = 8, RW = 7, CW = 3, NC = 8, KW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0;
  logic [NS-1:0] op_valid_i = '0, op_mem_i = '0;
  logic [NS*CW-1:0] op_class_i = '0;
  logic [NS*RW-1:0] op_reg_i = '0;
  logic stall_o, issue_o;
  logic [NS-1:0] grant_o;
  logic [NC*KW-1:0] grant_cnt_o;
  logic [NS*CW-1:0] grant_class_o;
  logic [NS*RW-1:0] grant_reg_o;

  always #4 clk = ~clk;  // 125 MHz

  opnd_read_sched dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
    .op_valid_i(op_valid_i), .op_mem_i(op_mem_i), .op_class_i(op_class_i),
    .op_reg_i(op_reg_i), .stall_o(stall_o), .issue_o(issue_o),
    .grant_o(grant_o), .grant_cnt_o(grant_cnt_o),
    .grant_class_o(grant_class_o), .grant_reg_o(grant_reg_o)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  int lim [NC] = '{4, 3, 1, 3, 1, 1, 3, 1};

  // reference model state
  bit m_busy;
  bit m_pend [NS];
  int m_cls [NS];
  int m_reg [NS];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic set_op(input int s, input bit v, input bit mem, input int cls, input int rg);
    op_valid_i[s] = v;
    op_mem_i[s] = mem;
    op_class_i[s*CW +: CW] = CW'(cls);
    op_reg_i[s*RW +: RW] = RW'(rg);
  endtask

  task automatic clear_ops();
    op_valid_i = '0; op_mem_i = '0; op_class_i = '0; op_reg_i = '0;
  endtask

  // Compare this cycle against the model, advance the model, move to next negedge.
  task automatic tick();
    int cnt [NC];
    logic [NS-1:0] eg;
    bit left, ei;
    foreach (cnt[c]) cnt[c] = 0;
    eg = '0; left = 0;
    for (int i = 0; i < NS; i++) begin
      if (m_busy && m_pend[i]) begin
        if (cnt[m_cls[i]] < lim[m_cls[i]]) begin
          eg[i] = 1'b1;
          cnt[m_cls[i]]++;
        end else left = 1;
      end
    end
    ei = m_busy && !left;
    chk(stall_o == m_busy, "R2 stall", stall_o, m_busy);
    chk(issue_o == ei, "R7 issue", issue_o, ei);
    chk(grant_o == eg, "R5 grant mask", grant_o, eg);
    for (int c = 0; c < NC; c++)
      chk(grant_cnt_o[c*KW +: KW] == KW'(cnt[c]), "R3 class count",
          grant_cnt_o[c*KW +: KW], cnt[c]);
    for (int i = 0; i < NS; i++)
      if (eg[i]) begin
        chk(grant_reg_o[i*RW +: RW] == RW'(m_reg[i]), "R11 reg", grant_reg_o[i*RW +: RW], m_reg[i]);
        chk(grant_class_o[i*CW +: CW] == CW'(m_cls[i]), "R11 class", grant_class_o[i*CW +: CW], m_cls[i]);
      end
    if (!m_busy && in_valid_i) begin
      m_busy = 1;
      for (int i = 0; i < NS; i++) begin
        m_pend[i] = op_valid_i[i] && !op_mem_i[i];
        m_cls[i] = int'(op_class_i[i*CW +: CW]);
        m_reg[i] = int'(op_reg_i[i*RW +: RW]);
      end
    end else if (m_busy) begin
      for (int i = 0; i < NS; i++) if (eg[i]) m_pend[i] = 0;
      if (ei) m_busy = 0;
    end
    @(negedge clk);
    cycles++;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    m_busy = 0;
    foreach (m_pend[i]) begin m_pend[i] = 0; m_cls[i] = 0; m_reg[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!stall_o && !issue_o && grant_o == '0 && grant_cnt_o == '0, "R1 reset", {stall_o, issue_o, grant_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!stall_o && !issue_o && grant_o == '0, "R1 after reset", {stall_o, issue_o, grant_o}, 0);

    // R4/R8: six integer, one condition-field, one memory slot
    clear_ops();
    for (int s = 0; s < 6; s++) set_op(s, 1, 0, 0, 10 + s);
    set_op(6, 1, 0, 3, 5);
    set_op(7, 1, 1, 0, 99);
    in_valid_i = 1; tick(); in_valid_i = 0;
    chk(grant_o == 8'h4F, "R4 mixed classes same cycle", grant_o, 8'h4F);
    chk(!issue_o, "R7 not yet", issue_o, 0);
    tick();
    chk(grant_o == 8'h30, "R6 remainder only", grant_o, 8'h30);
    chk(issue_o, "R8 memory slot does not delay issue", issue_o, 1);
    tick();
    chk(!stall_o, "R7 stall released", stall_o, 0);

    // R3: four slow special-purpose operands, one per cycle
    clear_ops();
    for (int s = 0; s < 4; s++) set_op(s + 2, 1, 0, 7, 40 + s);
    in_valid_i = 1; tick(); in_valid_i = 0;
    for (int k = 0; k < 4; k++) begin
      chk(grant_o == (8'h04 << k), "R3 one slow read per cycle", grant_o, 8'h04 << k);
      chk(issue_o == (k == 3), "R7 issue on last", issue_o, k == 3);
      tick();
    end

    // R9: no register operands (only a memory slot)
    clear_ops();
    set_op(0, 1, 1, 0, 1);
    in_valid_i = 1; tick(); in_valid_i = 0;
    chk(issue_o && grant_o == '0, "R9 empty issues next cycle", {issue_o, grant_o}, 9'h100);
    tick();

    // R10: input during stall ignored, next instruction captured after issue
    clear_ops();
    set_op(0, 1, 0, 2, 7); set_op(1, 1, 0, 2, 8);
    in_valid_i = 1; tick();
    clear_ops();
    for (int s = 0; s < NS; s++) set_op(s, 1, 0, 0, s);
    chk(grant_o == 8'h01, "R10 first CR read", grant_o, 8'h01);
    tick();
    chk(grant_o == 8'h02 && issue_o, "R10 stall input ignored", {issue_o, grant_o}, 9'h102);
    tick();
    chk(!stall_o, "R10 capture cycle after issue", stall_o, 0);
    tick(); in_valid_i = 0;
    chk(grant_o == 8'h0F && stall_o, "R10 new instruction grants", grant_o, 8'h0F);
    tick();
    chk(grant_o == 8'hF0 && issue_o, "R5 second integer group", grant_o, 8'hF0);
    tick();

    // random traffic, model-checked every cycle
    for (int n = 0; n < 3000; n++) begin
      clear_ops();
      for (int s = 0; s < NS; s++)
        set_op(s, ($urandom % 4) != 0, ($urandom % 6) == 0, $urandom % NC, $urandom % 128);
      in_valid_i = ($urandom % 3) != 0;
      tick();
    end
    in_valid_i = 0;
    repeat (10) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule